// File: doc/BRIEF.md
# Low-Power Gated-Output Scan Chain

This block is a row of N scan flip-flop cells. It stands between the state registers of a design and the combinational logic that those registers feed. Each cell has two outputs.

- The **functional output** drives the logic under test.
- The **chain output** is kept apart from it and feeds the next cell.

A single shift-select input chooses what every cell does on each rising clock edge:

- **Select low:** each cell captures its own bit of a parallel data vector.
- **Select high:** the cells form a serial shift path from the serial input to the serial output.

While shift-select is high, every functional output is held at zero. The logic downstream therefore sees one steady value for the whole load or unload, and does not switch on every shift clock. When shift-select drops, the functional outputs show the stored bits again at once. The chain output always carries the stored bit, whatever the mode.

A typical test sequence has four steps:

1. Shift a pattern in over N clocks.
2. Drop shift-select for one capture clock.
3. Raise it again.
4. Shift the captured state out over N clocks, last cell first.

Top module: `gated_scan_chain`

## Requirements
- R1: A synchronous active-high reset clears every stored bit. After the reset edge, `func_q` is all zeros and `scan_out` is 0.
- R2: While `shift_en` is 1, `func_q` is all zeros. It does not change during any cycle in which the chain shifts.
- R3: When `shift_en` is 0 at a rising edge, cell i stores `func_d[i]`. `func_q[i]` then equals that stored bit.
- R4: When `shift_en` is 1 at a rising edge, cell 0 stores `scan_in` and cell i stores the previous bit of cell i-1. The pattern advances one cell per clock.
- R5: `scan_out` always equals the bit stored in cell N-1, whichever mode is selected.
- R6: After N shift clocks, a serial pattern is fully loaded. The first bit entered sits in cell N-1. N further shift clocks present the stored state on `scan_out` in order, cell N-1 first.
- R7: In the cycle that `shift_en` falls to 0, `func_q` shows the stored bits with no added cycle of latency.
- R8: While `shift_en` is 1, `func_d` has no effect on the stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | 1 = serial shift with functional outputs gated low, 0 = parallel capture |
| scan_in | input | 1 | Serial input to cell 0 |
| func_d | input | N | Parallel capture data, bit i to cell i |
| func_q | output | N | Functional outputs to the logic under test, zero during shift |
| scan_out | output | 1 | Stored bit of cell N-1 |

## Verification
Two things meet in the same cycle: the last shift clock of a load, and the edge where the functional outputs come out of gating.

- **Exit from shift.** The bench drops `shift_en` right after the final shift. That cycle's `func_q` must already equal the loaded pattern while `scan_out` still shows cell N-1. The stored bits are then overwritten by capture on the next edge.
- **Reset during shift.** A reset is asserted while `shift_en` stays high. Clear and gating must then agree on an all-zero output.

Each cycle the bench compares both outputs against a queue model. During shifts it drives `func_d` with data that differs from the stored bits, so that any leak into the chain or onto `func_q` shows up.

// File: rtl/gated_scan_chain.sv
module gated_scan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic [N-1:0] func_q,
  output logic         scan_out
);

  logic [N-1:0] state;
  logic [N-1:0] chain_src;

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign chain_src[i] = scan_in;
    end else begin : g_link
      assign chain_src[i] = state[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)           state[i] <= 1'b0;
      else if (shift_en) state[i] <= chain_src[i];
      else               state[i] <= func_d[i];
    end

    assign func_q[i] = state[i] & ~shift_en;
  end

  assign scan_out = state[N-1];

endmodule

module gated_scan_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         scan_in,
  input logic [N-1:0] func_d,
  input logic [N-1:0] func_q,
  input logic [N-1:0] state,
  input logic         scan_out
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (state == '0 && scan_out == 1'b0));

  p_gated_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    shift_en |-> func_q == '0);

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (shift_en && $past(shift_en) && !$past(rst)) |-> $stable(func_q));

  p_capture_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!shift_en && !$past(shift_en) && !$past(rst)) |-> func_q == $past(func_d));

  p_head_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(shift_en) && !$past(rst)) |-> state[0] == $past(scan_in));

  if (N > 1) begin : g_body
    p_advance_r4: assert property (@(posedge clk) disable iff (rst || !armed)
      ($past(shift_en) && !$past(rst)) |-> state[N-1:1] == $past(state[N-2:0]));
  end

  p_tail_r5: assert property (@(posedge clk) disable iff (!armed)
    scan_out == state[N-1]);

  p_exit_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(shift_en) |-> func_q == state);

endmodule

bind gated_scan_chain gated_scan_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .scan_in(scan_in),
  .func_d(func_d), .func_q(func_q), .state(state), .scan_out(scan_out)
);

// File: tb/test_gated_scan_chain.sv
module test_gated_scan_chain;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] func_q;
  logic         scan_out;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model [N];
  logic [N-1:0] lfsr = 8'h5A;
  bit unload [$];

  always #4 clk = ~clk;

  gated_scan_chain #(.N(N)) i_gated_scan_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .scan_in(scan_in),
    .func_d(func_d), .func_q(func_q), .scan_out(scan_out)
  );

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model[i];
    return v;
  endfunction

  // Applies one cycle of stimulus at a falling edge, checks the outputs, then advances the model.
  task automatic cyc(input logic r, input logic se, input logic si,
                     input logic [N-1:0] d, input string tag);
    logic [N-1:0] exp_q;
    rst = r; shift_en = se; scan_in = si; func_d = d;
    #1;
    exp_q = se ? '0 : model_vec();
    vectors++;
    if (func_q !== exp_q || scan_out !== model[N-1]) begin
      errors++;
      $display("FAIL %s: func_q=%h scan_out=%b expected func_q=%h scan_out=%b",
               tag, func_q, scan_out, exp_q, model[N-1]);
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < N; i++) model[i] = 1'b0;
    end else if (se) begin
      for (int i = N-1; i > 0; i--) model[i] = model[i-1];
      model[0] = si;
    end else begin
      for (int i = 0; i < N; i++) model[i] = d[i];
    end
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] step_lfsr(input logic [N-1:0] s);
    return {s[N-2:0], s[N-1] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    @(negedge clk);
    cyc(1, 0, 0, '1, "R1");
    cyc(0, 0, 0, 8'h55, "R1");
    cyc(0, 0, 0, 8'hAA, "R3");
    cyc(0, 0, 0, 8'hFF, "R3");
    cyc(0, 0, 0, 8'h00, "R3");
    cyc(0, 0, 0, 8'hC3, "R3");
    for (int k = 0; k < 6; k++) begin
      lfsr = step_lfsr(lfsr);
      cyc(0, 0, 0, lfsr, "R3");
    end
    // Load 10110010 serially; R8: func_d toggles and must be ignored.
    for (int k = 0; k < N; k++) begin
      cyc(0, 1, (8'b10110010 >> (N-1-k)) & 1'b1, (k[0] ? 8'hFF : 8'h00), "R2 R4 R8");
    end
    // R7: leave shift; functional outputs show the loaded pattern in the same cycle.
    cyc(0, 0, 0, 8'h3C, "R7 R6");
    cyc(0, 0, 0, 8'h3C, "R5");
    // Unload captured state (R6), cell N-1 first, with simultaneous load of ones.
    for (int k = 0; k < N; k++) begin
      unload.push_back(scan_out);
      cyc(0, 1, 1, ~model_vec(), "R6 R2 R8");
    end
    unload.push_back(scan_out);
    // unload[0..N-1] must equal 3C bits N-1 down to 0
    for (int k = 0; k < N; k++) begin
      vectors++;
      if (unload[k] !== ((8'h3C >> (N-1-k)) & 1'b1)) begin
        errors++;
        $display("FAIL R6: unload bit %0d = %b expected %b", k, unload[k],
                 (8'h3C >> (N-1-k)) & 1'b1);
      end
    end
    // R1: reset while shifting
    cyc(0, 1, 1, '0, "R4");
    cyc(1, 1, 1, '1, "R1 R2");
    cyc(0, 1, 0, '1, "R1 R2");
    cyc(0, 0, 0, 8'h81, "R7");
    cyc(0, 0, 0, 8'h18, "R3 R5");
    // Walking one through the chain, R4 R5
    cyc(0, 1, 1, '0, "R4");
    for (int k = 0; k < N+1; k++) cyc(0, 1, 0, 8'hA5, "R4 R5");
    cyc(0, 0, 0, 8'h00, "R7");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule